// File: doc/BRIEF.md
# Edge-Interrupt Pin Bank Controller

This block is a register-mapped controller for a bank of general-purpose pins, sixteen by default. Each pin can be an input or an output, and software reads and drives the pins through a simple single-cycle 32-bit register bus. Input levels pass through a synchronizer before they are read or checked for edges. Output levels are changed only through atomic set-mask and clear-mask writes, so software never has to read, modify and write back the output register.

Each pin has a two-bit trigger selector. When the selected edge appears on the synchronized input, the pin's pending bit latches, whether or not its interrupt is enabled. Pending bits are cleared by writing one to them. One level-high interrupt line reports any pending bit whose enable is set. A second output, a wakeup request, reports any pending bit whose wakeup enable is set, but only while the global wakeup bit is on.

A configuration register holds the global wakeup bit, a stored autoidle bit and a stored two-bit idle-mode field. It also holds a soft-reset bit that returns every register to its default, and a reset-done flag reports when that soft reset has finished.

Top module: `pinbank_ctrl`

## Requirements
- R1: After the hardware reset, the register values are as follows. Direction (index 2) reads all ones, so every pin is an input. Output data (index 4) is 0. Both trigger registers are 0. Pending status is 0, and both enable registers are 0. Reset-done (index 1, bit 0) is 1. The outputs `gpio_out`, `gpio_oe`, `irq` and `wake_req` are all low.
- R2: Direction register bit = 1 makes the pin an input (`gpio_oe` bit low). Direction bit = 0 makes the pin an output (`gpio_oe` bit high). The register reads back as written.
- R3: The input register (index 3) shows `gpio_in` after a two-flop synchronizer. A pin change driven before clock edge n is first readable after edge n+1, and is not yet readable after edge n.
- R4: Writing a mask to the set-output index (5) ORs that mask into the output data. Writing a mask to the clear-output index (6) clears the masked bits. Zero bits in the mask leave their pins unchanged. Output data reads at index 4 and drives `gpio_out`. Writes to index 4 are ignored.
- R5: Trigger fields are two bits per pin. Pins 0..7 use index 7 and pins 8..15 use index 8, with each field at bits 2*(pin mod 8)+1 : 2*(pin mod 8). The codes are 00 none, 01 rising edge, 10 falling edge, 11 both edges. Both registers read back as written.
- R6: A pending bit latches when the configured edge occurs on the synchronized pin, even if that pin's interrupt enable is clear. With code 00, no edge latches anything.
- R7: Pending status (index 9) is write-one-to-clear. Writing 0 to a bit leaves it unchanged. If an edge and a clearing write land on the same bit in the same cycle, the edge wins and the bit stays set.
- R8: Interrupt enable reads at index 10. Index 11 sets enable bits and index 12 clears them, with write-one semantics. `irq` is high exactly while some pending bit has its enable set.
- R9: Wakeup enable reads at index 13. Index 14 sets wakeup-enable bits and index 15 clears them. `wake_req` is high when configuration bit 2 (global wakeup) is 1 and some pending bit has its wakeup enable set.
- R10: The configuration register (index 0) stores autoidle at bit 1, global wakeup at bit 2, and idle mode at bits 4:3, where code 2 means smart idle. These fields read back as written.
- R11: Writing 1 to configuration bit 0 returns every register to its R1 default. Reset-done then reads 0 after that write's clock edge and the next three edges, and reads 1 from the fourth edge on. Bit 0 reads 0 again once the soft reset is done. Writes are ignored while the soft reset is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read strobe |
| gpio_in | input | 16 | Pin levels, asynchronous |
| gpio_out | output | 16 | Output data |
| gpio_oe | output | 16 | Per-pin output enable |
| irq | output | 1 | Level-high interrupt |
| wake_req | output | 1 | Wakeup request |

## Verification
The hardest case to reach from the ports is the collision between a clearing write and a fresh edge on the same pending bit. The edge's detect pulse lasts only one cycle, and it arrives three edges after the pin moves. The bench changes the pin on a falling clock edge and lets two rising edges pass. It then drives the clear write so that the third edge samples the write together with the detect pulse, and it confirms that the bit is still set afterwards. The four-cycle soft-reset window is checked by polling reset-done once per cycle, starting right after the write.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

   localparam int unsigned REG_IDX_W = 4;

   typedef enum logic [REG_IDX_W-1:0] {
      RI_CFG       = 4'd0,
      RI_STAT      = 4'd1,
      RI_DIR       = 4'd2,
      RI_DIN       = 4'd3,
      RI_DOUT      = 4'd4,
      RI_DOUT_SET  = 4'd5,
      RI_DOUT_CLR  = 4'd6,
      RI_TRIG_LO   = 4'd7,
      RI_TRIG_HI   = 4'd8,
      RI_PEND      = 4'd9,
      RI_IEN       = 4'd10,
      RI_IEN_SET   = 4'd11,
      RI_IEN_CLR   = 4'd12,
      RI_WEN       = 4'd13,
      RI_WEN_SET   = 4'd14,
      RI_WEN_CLR   = 4'd15
   } reg_idx_e;

   // configuration bit positions
   localparam int unsigned CFG_SRST_BIT  = 0;
   localparam int unsigned CFG_AIDLE_BIT = 1;
   localparam int unsigned CFG_WAKE_BIT  = 2;
   localparam int unsigned CFG_IDLE_LSB  = 3;

   // trigger code bit meanings: bit0 = rising, bit1 = falling
   localparam logic [1:0] TRIG_NONE = 2'b00;
   localparam logic [1:0] TRIG_RISE = 2'b01;
   localparam logic [1:0] TRIG_FALL = 2'b10;
   localparam logic [1:0] TRIG_BOTH = 2'b11;

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pinbank_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= '{default: '0};
      end else if (clr) begin
         st <= '{default: '0};
      end else begin
         st[0] <= d;
         for (int k = 1; k < STAGES; k++) begin
            st[k] <= st[k-1];
         end
      end
   end

   assign q = st[STAGES-1];

endmodule

// File: rtl/pinbank_edge.sv
module pinbank_edge #(
   parameter int unsigned NUM_PINS = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic [NUM_PINS-1:0]   lvl,
   input  logic [2*NUM_PINS-1:0] trig,
   output logic [NUM_PINS-1:0]   hit
);

   logic [NUM_PINS-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   prev_q <= '0;
      else if (clr) prev_q <= '0;
      else          prev_q <= lvl;
   end

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic up, down;
      assign up     = lvl[i] & ~prev_q[i];
      assign down   = ~lvl[i] & prev_q[i];
      assign hit[i] = (trig[2*i] & up) | (trig[2*i+1] & down);
   end

endmodule

// File: rtl/pinbank_rstseq.sv
module pinbank_rstseq #(
   parameter int unsigned DONE_DLY = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);

   if (DONE_DLY < 1) begin : g_bad_dly
      $error("pinbank_rstseq: DONE_DLY must be at least 1");
   end

   localparam int unsigned CNT_W = $clog2(DONE_DLY + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DONE_DLY - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b1;
         cnt_q <= '0;
      end else if (busy) begin
         if (cnt_q == LAST) begin
            busy <= 1'b0;
            done <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else if (start) begin
         busy  <= 1'b1;
         done  <= 1'b0;
         cnt_q <= '0;
      end
   end

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
   import pinbank_pkg::*;
#(
   parameter int unsigned NUM_PINS     = 16,
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned RST_DONE_DLY = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [REG_IDX_W-1:0] bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [NUM_PINS-1:0]  gpio_in,
   output logic [NUM_PINS-1:0]  gpio_out,
   output logic [NUM_PINS-1:0]  gpio_oe,
   output logic                 irq,
   output logic                 wake_req
);

   localparam int unsigned HALF   = NUM_PINS / 2;
   localparam int unsigned TRIG_W = 2 * NUM_PINS;
   localparam int unsigned HALF_W = 2 * HALF;

   if ((NUM_PINS % 2) != 0 || NUM_PINS < 2) begin : g_bad_pins
      $error("pinbank_ctrl: NUM_PINS must be even and at least 2");
   end
   if (NUM_PINS > DATA_W) begin : g_bad_width
      $error("pinbank_ctrl: NUM_PINS must not exceed DATA_W");
   end
   if (DATA_W < CFG_IDLE_LSB + 2) begin : g_bad_cfg
      $error("pinbank_ctrl: DATA_W too narrow for configuration fields");
   end

   // register state
   logic [NUM_PINS-1:0] dir_q, dout_q, pend_q, ien_q, wen_q;
   logic [TRIG_W-1:0]   trig_q;
   logic                aidle_q, wake_q;
   logic [1:0]          idle_q;

   logic                srst_busy, done;
   logic [NUM_PINS-1:0] lvl, hit;

   wire                 unused_wdata = ^bus_wdata;

   logic wr_en, soft_start, clr_all;
   logic [NUM_PINS-1:0] wmask, pend_clr;

   assign wr_en      = bus_sel & bus_wr & ~srst_busy;
   assign wmask      = bus_wdata[NUM_PINS-1:0];
   assign soft_start = wr_en && (bus_addr == RI_CFG) && bus_wdata[CFG_SRST_BIT];
   assign clr_all    = soft_start | srst_busy;
   assign pend_clr   = (wr_en && bus_addr == RI_PEND) ? wmask : '0;

   pinbank_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_all),
      .d     (gpio_in),
      .q     (lvl)
   );

   pinbank_edge #(
      .NUM_PINS (NUM_PINS)
   ) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_all),
      .lvl   (lvl),
      .trig  (trig_q),
      .hit   (hit)
   );

   pinbank_rstseq #(
      .DONE_DLY (RST_DONE_DLY)
   ) u_rstseq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (soft_start),
      .busy  (srst_busy),
      .done  (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '1;
         dout_q  <= '0;
         trig_q  <= '0;
         pend_q  <= '0;
         ien_q   <= '0;
         wen_q   <= '0;
         aidle_q <= 1'b0;
         wake_q  <= 1'b0;
         idle_q  <= 2'b00;
      end else if (clr_all) begin
         dir_q   <= '1;
         dout_q  <= '0;
         trig_q  <= '0;
         pend_q  <= '0;
         ien_q   <= '0;
         wen_q   <= '0;
         aidle_q <= 1'b0;
         wake_q  <= 1'b0;
         idle_q  <= 2'b00;
      end else begin
         // an edge in the same cycle as a clear keeps the bit set
         pend_q <= (pend_q & ~pend_clr) | hit;
         if (wr_en) begin
            case (reg_idx_e'(bus_addr))
               RI_CFG: begin
                  aidle_q <= bus_wdata[CFG_AIDLE_BIT];
                  wake_q  <= bus_wdata[CFG_WAKE_BIT];
                  idle_q  <= bus_wdata[CFG_IDLE_LSB +: 2];
               end
               RI_DIR:      dir_q  <= wmask;
               RI_DOUT_SET: dout_q <= dout_q | wmask;
               RI_DOUT_CLR: dout_q <= dout_q & ~wmask;
               RI_TRIG_LO:  trig_q[HALF_W-1:0]      <= bus_wdata[HALF_W-1:0];
               RI_TRIG_HI:  trig_q[TRIG_W-1:HALF_W] <= bus_wdata[HALF_W-1:0];
               RI_IEN_SET:  ien_q  <= ien_q | wmask;
               RI_IEN_CLR:  ien_q  <= ien_q & ~wmask;
               RI_WEN_SET:  wen_q  <= wen_q | wmask;
               RI_WEN_CLR:  wen_q  <= wen_q & ~wmask;
               default: ;
            endcase
         end
      end
   end

   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      case (reg_idx_e'(bus_addr))
         RI_CFG: begin
            rd_mux[CFG_SRST_BIT]      = srst_busy;
            rd_mux[CFG_AIDLE_BIT]     = aidle_q;
            rd_mux[CFG_WAKE_BIT]      = wake_q;
            rd_mux[CFG_IDLE_LSB +: 2] = idle_q;
         end
         RI_STAT:    rd_mux[0]              = done;
         RI_DIR:     rd_mux[NUM_PINS-1:0]   = dir_q;
         RI_DIN:     rd_mux[NUM_PINS-1:0]   = lvl;
         RI_DOUT:    rd_mux[NUM_PINS-1:0]   = dout_q;
         RI_TRIG_LO: rd_mux[HALF_W-1:0]     = trig_q[HALF_W-1:0];
         RI_TRIG_HI: rd_mux[HALF_W-1:0]     = trig_q[TRIG_W-1:HALF_W];
         RI_PEND:    rd_mux[NUM_PINS-1:0]   = pend_q;
         RI_IEN:     rd_mux[NUM_PINS-1:0]   = ien_q;
         RI_WEN:     rd_mux[NUM_PINS-1:0]   = wen_q;
         default:    rd_mux                 = '0;
      endcase
   end

   assign bus_rdata = (bus_sel && !bus_wr) ? rd_mux : '0;
   assign gpio_out  = dout_q;
   assign gpio_oe   = ~dir_q;
   assign irq       = |(pend_q & ien_q);
   assign wake_req  = wake_q & (|(pend_q & wen_q));

endmodule

module pinbank_ctrl_chk
   import pinbank_pkg::*;
#(
   parameter int unsigned NUM_PINS = 16,
   parameter int unsigned DATA_W   = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_sel,
   input logic                  bus_wr,
   input logic [REG_IDX_W-1:0]  bus_addr,
   input logic [DATA_W-1:0]     bus_wdata,
   input logic [NUM_PINS-1:0]   gpio_out,
   input logic [NUM_PINS-1:0]   gpio_oe,
   input logic                  irq,
   input logic                  rst_done,
   input logic [NUM_PINS-1:0]   pend_q,
   input logic [2*NUM_PINS-1:0] trig_q,
   input logic [NUM_PINS-1:0]   ien_q
);

   logic wr_any;
   assign wr_any = bus_sel & bus_wr;

   // R11
   srst_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_any && bus_addr == RI_CFG && bus_wdata[CFG_SRST_BIT] && rst_done) |=> !rst_done);

   // R11
   srst_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_done |-> (gpio_oe == '0));

   // R6
   no_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_q == '0) |=> ((pend_q & ~$past(pend_q)) == '0));

   // R4
   dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_any && (bus_addr == RI_DOUT_SET || bus_addr == RI_DOUT_CLR || bus_addr == RI_CFG))
      |=> $stable(gpio_out));

   // R8
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q == '0) |-> !irq);

   // R7
   pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_any && (bus_addr == RI_PEND || bus_addr == RI_CFG))
      |=> ((~pend_q & $past(pend_q)) == '0));

endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(
   .NUM_PINS (NUM_PINS),
   .DATA_W   (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .gpio_out  (gpio_out),
   .gpio_oe   (gpio_oe),
   .irq       (irq),
   .rst_done  (done),
   .pend_q    (pend_q),
   .trig_q    (trig_q),
   .ien_q     (ien_q)
);

// File: tb/pinbank_ctrl_tb.sv
module pinbank_ctrl_tb;
   import pinbank_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] gpio_in = '0;
   logic [15:0] gpio_out, gpio_oe;
   logic        irq, wake_req;

   int checks = 0;
   int errors = 0;
   bit ended  = 1'b0;

   always #10 clk = ~clk;

   pinbank_ctrl u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .gpio_in   (gpio_in),
      .gpio_out  (gpio_out),
      .gpio_oe   (gpio_oe),
      .irq       (irq),
      .wake_req  (wake_req)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input reg_idx_e a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input reg_idx_e a, output logic [31:0] v);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 v = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic set_pins(input logic [15:0] v);
      @(negedge clk);
      gpio_in = v;
   endtask

   task automatic settle();
      repeat (4) @(posedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(RI_DIR, v);      chk("R1 dir default", v, 32'h0000_FFFF);
      rd(RI_DOUT, v);     chk("R1 dout default", v, 32'h0);
      rd(RI_TRIG_LO, v);  chk("R1 trig lo default", v, 32'h0);
      rd(RI_TRIG_HI, v);  chk("R1 trig hi default", v, 32'h0);
      rd(RI_PEND, v);     chk("R1 pending default", v, 32'h0);
      rd(RI_IEN, v);      chk("R1 irq enable default", v, 32'h0);
      rd(RI_WEN, v);      chk("R1 wake enable default", v, 32'h0);
      rd(RI_STAT, v);     chk("R1 reset done", v, 32'h1);
      chk("R1 outputs", {gpio_out, gpio_oe}, 32'h0);
      chk("R1 irq/wake", {30'h0, irq, wake_req}, 32'h0);
   endtask

   task automatic t_dir();
      logic [31:0] v;
      wr(RI_DIR, 32'h0000_00F0);
      rd(RI_DIR, v);  chk("R2 dir readback", v, 32'h0000_00F0);
      chk("R2 oe from dir", {16'h0, gpio_oe}, 32'h0000_FF0F);
      wr(RI_DIR, 32'h0000_FFFF);
      chk("R2 all inputs", {16'h0, gpio_oe}, 32'h0);
   endtask

   task automatic t_din();
      logic [31:0] v;
      set_pins(16'hA5C3);
      rd(RI_DIN, v);  chk("R3 din after one edge", v, 32'h0);
      rd(RI_DIN, v);  chk("R3 din after two edges", v, 32'h0000_A5C3);
      set_pins(16'h0000);
      settle();
      rd(RI_DIN, v);  chk("R3 din back to zero", v, 32'h0);
   endtask

   task automatic t_dout();
      logic [31:0] v;
      wr(RI_DOUT_SET, 32'h0000_0011);
      rd(RI_DOUT, v);  chk("R4 set mask", v, 32'h0000_0011);
      wr(RI_DOUT_SET, 32'h0000_0100);
      chk("R4 set keeps others", {16'h0, gpio_out}, 32'h0000_0111);
      wr(RI_DOUT_CLR, 32'h0000_0010);
      rd(RI_DOUT, v);  chk("R4 clear mask", v, 32'h0000_0101);
      wr(RI_DOUT, 32'h0000_FFFF);
      rd(RI_DOUT, v);  chk("R4 direct write ignored", v, 32'h0000_0101);
   endtask

   task automatic t_trig();
      logic [31:0] v;
      // pin1 rise, pin2 fall, pin3 both, pin9 rise, pin10 none
      wr(RI_TRIG_LO, 32'h0000_00E4);
      wr(RI_TRIG_HI, 32'h0000_0004);
      rd(RI_TRIG_LO, v);  chk("R5 trig lo readback", v, 32'h0000_00E4);
      rd(RI_TRIG_HI, v);  chk("R5 trig hi readback", v, 32'h0000_0004);
      set_pins(16'h060E);
      settle();
      rd(RI_PEND, v);  chk("R6 rising edges latch without enable", v, 32'h0000_020A);
      chk("R8 no irq with enables clear", {31'h0, irq}, 32'h0);
      wr(RI_PEND, 32'h0000_FFFF);
      set_pins(16'h0000);
      settle();
      rd(RI_PEND, v);  chk("R6 falling edges latch", v, 32'h0000_000C);
      wr(RI_PEND, 32'h0000_FFFF);
      rd(RI_PEND, v);  chk("R7 all cleared", v, 32'h0);
   endtask

   task automatic t_irq();
      logic [31:0] v;
      wr(RI_IEN_SET, 32'h0000_0002);
      rd(RI_IEN, v);  chk("R8 enable set", v, 32'h0000_0002);
      chk("R8 no pending no irq", {31'h0, irq}, 32'h0);
      set_pins(16'h0202);
      settle();
      chk("R8 irq asserted", {31'h0, irq}, 32'h1);
      wr(RI_PEND, 32'h0000_0200);
      chk("R8 irq held by enabled bit", {31'h0, irq}, 32'h1);
      wr(RI_PEND, 32'h0000_0002);
      chk("R8 irq released", {31'h0, irq}, 32'h0);
      wr(RI_IEN_CLR, 32'h0000_0002);
      rd(RI_IEN, v);  chk("R8 enable cleared", v, 32'h0);
      set_pins(16'h0000);
      settle();
   endtask

   task automatic t_w1c();
      logic [31:0] v;
      set_pins(16'h0002);
      settle();
      rd(RI_PEND, v);  chk("R6 pin1 latched", v, 32'h0000_0002);
      wr(RI_PEND, 32'h0);
      rd(RI_PEND, v);  chk("R7 write zero keeps", v, 32'h0000_0002);
      wr(RI_PEND, 32'h0000_0002);
      rd(RI_PEND, v);  chk("R7 write one clears", v, 32'h0);
      // collision: clear sampled on the same edge as pin3's detect pulse
      set_pins(16'h000A);
      @(posedge clk);
      @(posedge clk);
      wr(RI_PEND, 32'h0000_0008);
      rd(RI_PEND, v);  chk("R7 edge beats clear", v, 32'h0000_0008);
      wr(RI_PEND, 32'h0000_0008);
      rd(RI_PEND, v);  chk("R7 later clear works", v, 32'h0);
   endtask

   task automatic t_wake();
      logic [31:0] v;
      wr(RI_CFG, 32'h0000_0004);
      wr(RI_WEN_SET, 32'h0000_0002);
      rd(RI_WEN, v);  chk("R9 wake enable set", v, 32'h0000_0002);
      chk("R9 no wake without pending", {31'h0, wake_req}, 32'h0);
      set_pins(16'h0000);
      settle();
      set_pins(16'h0002);
      settle();
      chk("R9 wake asserted", {31'h0, wake_req}, 32'h1);
      wr(RI_WEN_CLR, 32'h0000_0002);
      chk("R9 wake released", {31'h0, wake_req}, 32'h0);
      rd(RI_WEN, v);  chk("R9 wake enable cleared", v, 32'h0);
      wr(RI_PEND, 32'h0000_FFFF);
   endtask

   task automatic t_cfg();
      logic [31:0] v;
      wr(RI_CFG, 32'h0000_0012);
      rd(RI_CFG, v);  chk("R10 idle mode and autoidle", v, 32'h0000_0012);
   endtask

   task automatic t_srst();
      logic [31:0] v;
      wr(RI_DIR, 32'h0);
      wr(RI_DOUT_SET, 32'h0000_0003);
      wr(RI_IEN_SET, 32'h0000_0001);
      wr(RI_CFG, 32'h0000_0001);
      for (int k = 1; k <= 3; k++) begin
         rd(RI_STAT, v);  chk("R11 done low while busy", v, 32'h0);
      end
      rd(RI_STAT, v);  chk("R11 done after four edges", v, 32'h1);
      rd(RI_CFG, v);   chk("R11 soft reset bit cleared", v, 32'h0);
      rd(RI_DIR, v);   chk("R11 dir restored", v, 32'h0000_FFFF);
      rd(RI_DOUT, v);  chk("R11 dout restored", v, 32'h0);
      rd(RI_IEN, v);   chk("R11 enable restored", v, 32'h0);
      rd(RI_TRIG_LO, v); chk("R11 trig restored", v, 32'h0);
      // writes during the busy window are ignored
      wr(RI_CFG, 32'h0000_0001);
      wr(RI_DIR, 32'h0000_0000);
      repeat (4) @(posedge clk);
      rd(RI_DIR, v);   chk("R11 write while busy ignored", v, 32'h0000_FFFF);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_dir();
      t_din();
      t_dout();
      t_trig();
      t_irq();
      t_w1c();
      t_wake();
      t_cfg();
      t_srst();
      if (!ended) begin
         ended = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule